// File: doc/BRIEF.md
# Multi-Size Address Translation Cache

This block keeps the most recent virtual-to-physical translations for a 32-bit virtual address space in a small fully associative store. Every entry maps one region of 4 KB, 64 KB, 1 MB or 16 MB. A larger region therefore needs only one slot, and one hit covers the whole region. A lookup is combinational. In the same cycle it gives either the physical address plus the stored attributes (domain, access permission, execute-never) or a miss indication. The translation is produced without any memory access.

On a miss, an external table walker writes the translation through the refill port, and the entry can be used from the next cycle on. Each entry is marked either as valid for every process or as belonging to one address space identifier. Software can drop every entry, or only the process-specific ones, in one cycle. The permission check, the walk and the data cache live elsewhere.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. A lookup then misses, and with lk_valid low both lk_hit and lk_miss are 0.
- R2: With lk_valid high, lk_hit rises in the same cycle when a valid entry matches, and otherwise lk_miss rises. On a miss, lk_paddr, lk_domain, lk_perm and lk_xn are all zero.
- R3: fill_size encodes the region: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. The tag compare ignores virtual address bits [11:0], [15:0], [19:0] or [23:0] respectively.
- R4: On a hit, lk_paddr takes the stored physical bits above the region boundary and the lookup address bits below it.
- R5: On a hit, lk_domain (4 bits), lk_perm (3 bits) and lk_xn return the values written with that entry.
- R6: An entry with fill_ng = 0 hits for any lk_asid. An entry with fill_ng = 1 hits only when lk_asid equals its stored 8-bit identifier.
- R7: A refill can be looked up in the very next cycle. While any entry is invalid, a refill goes into the lowest-index invalid entry.
- R8: When all entries are valid, a refill replaces the entry named by a round-robin pointer. The pointer is 0 after reset, advances by one per such replacement and wraps from the last entry to 0.
- R9: inv_all clears every entry in one cycle and wins over a refill in the same cycle, which is dropped.
- R10: inv_nonglobal clears, in one cycle, exactly the entries whose not-global flag is 1. Global entries keep hitting. A refill in the same cycle is dropped.
- R11: When several entries match one lookup, the lowest-index entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup requested but no entry matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_domain | output | 4 | Domain of the hitting entry |
| lk_perm | output | 3 | Access permission code of the hitting entry |
| lk_xn | output | 1 | Execute-never flag of the hitting entry |
| fill_valid | input | 1 | Write a new translation |
| fill_vaddr | input | 32 | Virtual base of the region |
| fill_paddr | input | 32 | Physical base of the region |
| fill_size | input | 2 | Region size code |
| fill_ng | input | 1 | 1 = process-specific, 0 = global |
| fill_asid | input | 8 | Identifier for process-specific entries |
| fill_domain | input | 4 | Domain to store |
| fill_perm | input | 3 | Access permission to store |
| fill_xn | input | 1 | Execute-never to store |
| inv_all | input | 1 | Invalidate every entry |
| inv_nonglobal | input | 1 | Invalidate process-specific entries |

## Verification
Lookup results are due in the cycle of the request itself. The bench therefore drives a request on the falling edge and compares it 1 ns later, before the next rising edge. Refills and invalidations take effect at the rising edge that follows the cycle in which they are driven. Every check of their effect is therefore a lookup driven on the very next falling edge, which also confirms the one-cycle latency. The driver queues each expected result, and the monitor pops one item for each cycle in which lk_valid is high.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int ASID_W  = 8;
    localparam int DOM_W   = 4;
    localparam int PERM_W  = 3;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } rgn_size_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        rgn_size_e         size;
        logic              ng;
        logic [ASID_W-1:0] asid;
        logic [DOM_W-1:0]  dom;
        logic [PERM_W-1:0] perm;
        logic              xn;
    } xlat_ent_t;

    // Bits of the page number that take part in the compare (1 = compared)
    function automatic logic [VPN_W-1:0] cmp_mask(rgn_size_e sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz)
            SZ_4K:   m = '1;
            SZ_64K:  m = {{(VPN_W-4){1'b1}}, 4'h0};
            SZ_1M:   m = {{(VPN_W-8){1'b1}}, 8'h00};
            default: m = {{(VPN_W-12){1'b1}}, 12'h000};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  xlat_ent_t          ent,
    input  logic               ent_vld,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [ASID_W-1:0]  look_asid,
    output logic               hit
);
    logic [VPN_W-1:0] mask;
    logic             tag_eq;
    logic             asid_ok;

    always_comb begin
        mask    = cmp_mask(ent.size);
        tag_eq  = ((look_vpn ^ ent.vpn) & mask) == '0;
        asid_ok = !ent.ng || (ent.asid == look_asid);
        hit     = ent_vld && tag_eq && asid_ok;
    end
endmodule

// File: rtl/xlat_hit_mux.sv
module xlat_hit_mux
    import xlat_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic [N_ENT-1:0] hit_vec,
    input  xlat_ent_t [N_ENT-1:0] ents,
    output logic             any_hit,
    output xlat_ent_t        sel
);
    always_comb begin
        any_hit = 1'b0;
        sel     = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                sel     = ents[i];
            end
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic             advance,
    output logic [IDX_W-1:0] victim,
    output logic             full
);
    typedef struct packed {
        logic [IDX_W-1:0] rr;
    } vic_state_t;

    vic_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        victim = st_q.rr;
        full   = 1'b1;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                victim = IDX_W'(i);
                full   = 1'b0;
            end
        end
        if (advance) begin
            st_d.rr = st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> st_q.rr == IDX_W'($past(st_q.rr) + 1'b1)); // R8
    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(st_q.rr)); // R8
    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !valid_vec[victim]); // R7
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [7:0]        lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [31:0]       lk_paddr,
    output logic [3:0]        lk_domain,
    output logic [2:0]        lk_perm,
    output logic              lk_xn,
    input  logic              fill_valid,
    input  logic [31:0]       fill_vaddr,
    input  logic [31:0]       fill_paddr,
    input  logic [1:0]        fill_size,
    input  logic              fill_ng,
    input  logic [7:0]        fill_asid,
    input  logic [3:0]        fill_domain,
    input  logic [2:0]        fill_perm,
    input  logic              fill_xn,
    input  logic              inv_all,
    input  logic              inv_nonglobal
);
    typedef struct packed {
        logic [N_ENTRIES-1:0]      valid;
        xlat_ent_t [N_ENTRIES-1:0] ent;
    } cache_state_t;

    cache_state_t st_d, st_q;

    logic [N_ENTRIES-1:0] hit_vec;
    logic [N_ENTRIES-1:0] ng_vec;
    logic                 any_hit;
    xlat_ent_t            sel;
    logic [IDX_W-1:0]     victim;
    logic                 full;
    logic                 fill_ok;
    logic                 rr_adv;
    logic [VPN_W-1:0]     sel_mask;
    logic [VPN_W-1:0]     out_pn;

    // Per-entry compare
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        xlat_match u_match (
            .ent       (st_q.ent[g]),
            .ent_vld   (st_q.valid[g]),
            .look_vpn  (lk_vaddr[VA_W-1:OFS_W]),
            .look_asid (lk_asid),
            .hit       (hit_vec[g])
        );
        assign ng_vec[g] = st_q.ent[g].ng;
    end

    xlat_hit_mux #(.N_ENT(N_ENTRIES)) u_mux (
        .hit_vec (hit_vec),
        .ents    (st_q.ent),
        .any_hit (any_hit),
        .sel     (sel)
    );

    xlat_victim #(.N_ENT(N_ENTRIES)) u_vic (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (st_q.valid),
        .advance   (rr_adv),
        .victim    (victim),
        .full      (full)
    );

    // Lookup result path
    always_comb begin
        sel_mask  = cmp_mask(sel.size);
        out_pn    = (sel.ppn & sel_mask) | (lk_vaddr[VA_W-1:OFS_W] & ~sel_mask);
        lk_hit    = lk_valid && any_hit;
        lk_miss   = lk_valid && !any_hit;
        lk_paddr  = lk_hit ? {out_pn, lk_vaddr[OFS_W-1:0]} : '0;
        lk_domain = lk_hit ? sel.dom  : '0;
        lk_perm   = lk_hit ? sel.perm : '0;
        lk_xn     = lk_hit && sel.xn;
    end

    // Next-state: invalidation first, then refill
    always_comb begin
        st_d    = st_q;
        fill_ok = fill_valid && !inv_all && !inv_nonglobal;
        rr_adv  = fill_ok && full;
        if (inv_all) begin
            st_d.valid = '0;
        end else if (inv_nonglobal) begin
            st_d.valid = st_q.valid & ~ng_vec;
        end else if (fill_ok) begin
            st_d.valid[victim]    = 1'b1;
            st_d.ent[victim].vpn  = fill_vaddr[VA_W-1:OFS_W];
            st_d.ent[victim].ppn  = fill_paddr[VA_W-1:OFS_W];
            st_d.ent[victim].size = rgn_size_e'(fill_size);
            st_d.ent[victim].ng   = fill_ng;
            st_d.ent[victim].asid = fill_asid;
            st_d.ent[victim].dom  = fill_domain;
            st_d.ent[victim].perm = fill_perm;
            st_d.ent[victim].xn   = fill_xn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> st_q.valid == '0); // R9
    AST_NG_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_nonglobal && !inv_all) |=> (st_q.valid & ng_vec) == '0); // R10
    AST_NG_FLUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_nonglobal && !inv_all) |=> (st_q.valid & ~ng_vec) == $past(st_q.valid & ~ng_vec)); // R10
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_all && !inv_nonglobal && !full)
        |=> $countones(st_q.valid) == $past($countones(st_q.valid)) + 1); // R7
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0 && lk_domain == '0 && lk_perm == '0 && !lk_xn)); // R2
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_xn;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_domain;
    logic [2:0]  lk_perm;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_vaddr = '0, fill_paddr = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_ng = 1'b0;
    logic [7:0]  fill_asid = '0;
    logic [3:0]  fill_domain = '0;
    logic [2:0]  fill_perm = '0;
    logic        fill_xn = 1'b0;
    logic        inv_all = 1'b0, inv_nonglobal = 1'b0;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  dom;
        logic [2:0]  perm;
        logic        xn;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_domain(lk_domain), .lk_perm(lk_perm), .lk_xn(lk_xn),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
        .fill_size(fill_size), .fill_ng(fill_ng), .fill_asid(fill_asid),
        .fill_domain(fill_domain), .fill_perm(fill_perm), .fill_xn(fill_xn),
        .inv_all(inv_all), .inv_nonglobal(inv_nonglobal)
    );

    task automatic ctrl(input logic f, input logic ia, input logic ing, input logic lk);
        fill_valid = f; inv_all = ia; inv_nonglobal = ing; lk_valid = lk;
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                           input logic ng, input logic [7:0] asid, input logic [3:0] dom,
                           input logic [2:0] perm, input logic xn);
        @(negedge clk);
        fill_vaddr = va; fill_paddr = pa; fill_size = sz; fill_ng = ng;
        fill_asid = asid; fill_domain = dom; fill_perm = perm; fill_xn = xn;
        ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_inv(input logic all_f, input logic ng_f, input logic with_fill);
        @(negedge clk);
        ctrl(with_fill, all_f, ng_f, 1'b0);
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic hit,
                        input logic [31:0] pa, input logic [3:0] dom, input logic [2:0] perm,
                        input logic xn, input string tag);
        exp_t e;
        @(negedge clk);
        ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        lk_vaddr = va; lk_asid = asid;
        e.hit = hit; e.pa = hit ? pa : 32'h0; e.dom = hit ? dom : 4'h0;
        e.perm = hit ? perm : 3'h0; e.xn = hit ? xn : 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic miss(input logic [31:0] va, input logic [7:0] asid, input string tag);
        look(va, asid, 1'b0, 32'h0, 4'h0, 3'h0, 1'b0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // Monitor: compares each lookup in its own cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (lk_valid && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_paddr !== e.pa ||
                    lk_domain !== e.dom || lk_perm !== e.perm || lk_xn !== e.xn) begin
                    failures++;
                    $display("FAIL %s: got hit=%b miss=%b pa=%h dom=%h perm=%h xn=%b exp hit=%b pa=%h dom=%h perm=%h xn=%b",
                             e.tag, lk_hit, lk_miss, lk_paddr, lk_domain, lk_perm, lk_xn,
                             e.hit, e.pa, e.dom, e.perm, e.xn);
                end
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle outputs: got hit=%b miss=%b expected 0 0", lk_hit, lk_miss);
        end
        miss(32'h1234_5678, 8'h05, "R1 empty after reset");

        // Four region sizes; size code 0=4K 1=64K 2=1M 3=16M
        do_fill(32'h0001_2000, 32'h8000_0000, 2'd0, 1'b0, 8'h00, 4'd3, 3'd5, 1'b0);
        do_fill(32'h0020_0000, 32'h9000_0000, 2'd1, 1'b0, 8'h00, 4'd7, 3'd2, 1'b1);
        do_fill(32'h0300_0000, 32'hA010_0000, 2'd2, 1'b1, 8'h05, 4'd9, 3'd1, 1'b0);
        do_fill(32'h4000_0000, 32'hB000_0000, 2'd3, 1'b1, 8'h06, 4'd12, 3'd6, 1'b1);
        look(32'h4000_0000, 8'h06, 1'b1, 32'hB000_0000, 4'd12, 3'd6, 1'b1, "R7 next-cycle hit");
        look(32'h0001_2ABC, 8'h05, 1'b1, 32'h8000_0ABC, 4'd3, 3'd5, 1'b0, "R2 R4 R5 4K hit");
        miss(32'h0001_3000, 8'h05, "R3 4K boundary");
        look(32'h0020_FFF4, 8'h05, 1'b1, 32'h9000_FFF4, 4'd7, 3'd2, 1'b1, "R3 64K hit");
        miss(32'h0021_0000, 8'h05, "R3 64K boundary");
        look(32'h030A_BCDE, 8'h05, 1'b1, 32'hA01A_BCDE, 4'd9, 3'd1, 1'b0, "R3 R4 1M hit");
        miss(32'h030A_BCDE, 8'h04, "R6 asid mismatch");
        look(32'h40FF_0010, 8'h06, 1'b1, 32'hB0FF_0010, 4'd12, 3'd6, 1'b1, "R3 16M hit");
        miss(32'h40FF_0010, 8'h05, "R6 16M asid mismatch");
        miss(32'h4100_0000, 8'h06, "R3 16M boundary");
        look(32'h0001_2010, 8'h77, 1'b1, 32'h8000_0010, 4'd3, 3'd5, 1'b0, "R6 global any asid");

        // Duplicate match: lower index wins
        do_fill(32'h0001_2000, 32'hC000_0000, 2'd0, 1'b0, 8'h00, 4'd1, 3'd1, 1'b1);
        look(32'h0001_2004, 8'h05, 1'b1, 32'h8000_0004, 4'd3, 3'd5, 1'b0, "R11 lowest index");

        // Non-global flush
        do_inv(1'b0, 1'b1, 1'b0);
        miss(32'h030A_BCDE, 8'h05, "R10 ng 1M cleared");
        miss(32'h40FF_0010, 8'h06, "R10 ng 16M cleared");
        look(32'h0020_0010, 8'h05, 1'b1, 32'h9000_0010, 4'd7, 3'd2, 1'b1, "R10 global kept");
        look(32'h0001_2008, 8'h05, 1'b1, 32'h8000_0008, 4'd3, 3'd5, 1'b0, "R10 global kept 4K");

        // Non-global flush with a refill in the same cycle: refill dropped
        fill_vaddr = 32'h0500_0000; fill_paddr = 32'h0600_0000; fill_size = 2'd0;
        fill_ng = 1'b0; fill_asid = 8'h00; fill_domain = 4'd2; fill_perm = 3'd2; fill_xn = 1'b0;
        do_inv(1'b0, 1'b1, 1'b1);
        miss(32'h0500_0000, 8'h05, "R10 refill dropped");

        // Full flush with a refill in the same cycle
        fill_vaddr = 32'h0700_0000; fill_paddr = 32'h0800_0000;
        do_inv(1'b1, 1'b0, 1'b1);
        miss(32'h0001_2000, 8'h05, "R9 all cleared");
        miss(32'h0020_0000, 8'h05, "R9 64K cleared");
        miss(32'h0700_0000, 8'h05, "R9 refill dropped");

        // Fill every slot; invalid-first places entry i in slot i
        for (int i = 0; i < 32; i++) begin
            do_fill(32'h1000_0000 + (i << 12), 32'h2000_0000 + (i << 12), 2'd0, 1'b0, 8'h00, 4'd0, 3'd0, 1'b0);
        end
        look(32'h1001_F000, 8'h05, 1'b1, 32'h2001_F000, 4'd0, 3'd0, 1'b0, "R7 last slot");
        look(32'h1000_0000, 8'h05, 1'b1, 32'h2000_0000, 4'd0, 3'd0, 1'b0, "R7 first slot");
        do_fill(32'h1100_0000, 32'h3100_0000, 2'd0, 1'b0, 8'h00, 4'd4, 3'd4, 1'b0);
        miss(32'h1000_0000, 8'h05, "R8 slot 0 replaced");
        look(32'h1000_1000, 8'h05, 1'b1, 32'h2000_1000, 4'd0, 3'd0, 1'b0, "R8 slot 1 kept");
        look(32'h1100_0000, 8'h05, 1'b1, 32'h3100_0000, 4'd4, 3'd4, 1'b0, "R8 new entry");
        do_fill(32'h1100_1000, 32'h3100_1000, 2'd0, 1'b0, 8'h00, 4'd4, 3'd4, 1'b0);
        miss(32'h1000_1000, 8'h05, "R8 slot 1 replaced");
        for (int k = 0; k < 30; k++) begin
            do_fill(32'h1200_0000 + (k << 12), 32'h3200_0000 + (k << 12), 2'd0, 1'b0, 8'h00, 4'd5, 3'd5, 1'b0);
        end
        miss(32'h1001_F000, 8'h05, "R8 slot 31 replaced");
        do_fill(32'h1300_0000, 32'h3300_0000, 2'd0, 1'b0, 8'h00, 4'd6, 3'd6, 1'b1);
        miss(32'h1100_0000, 8'h05, "R8 wrap to slot 0");
        look(32'h1100_1000, 8'h05, 1'b1, 32'h3100_1000, 4'd4, 3'd4, 1'b0, "R8 slot 1 after wrap");
        look(32'h1300_0000, 8'h05, 1'b1, 32'h3300_0000, 4'd6, 3'd6, 1'b1, "R8 wrap entry");

        idle();
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule